// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block sits in the outbound path of a cell-based line interface. Cells of 53 octets arrive one octet per strobe. The first octet carries a start marker, and a tag says whether the cell carries user data or is an idle filler. The block first verifies the integrity-check octet found in header position five. It can then overwrite the top nibble of the first header octet with bits taken from a serial pin, and replace octet five with a header check sequence (a CRC-8, optionally offset by a coset). Finally it can pass the 48 payload octets through a self-synchronising scrambler. Every octet leaves the block exactly one clock after it entered.

A single 8-bit control register holds the enables and a sticky integrity-error flag. The flag clears when the register is read, and software cannot set or clear it by writing. An interrupt line reflects the flag, gated by its enable bit. If 53 octets pass without a new start marker, the next octet begins a new cell and keeps the previous cell's tag.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: After reset the control register reads 0xF2: bit7 scramble enable=1, bit6 coset enable=1, bit5 valid-cell check-sequence enable=1, bit4 constant-pattern select=1, bit3 nibble insert enable=0, bit2 interrupt enable=0, bit1 idle-cell check-sequence enable=1, bit0 error flag=0. `irq` and `out_valid` are low.
- R2: Each octet strobed in with `in_valid` appears on `out_data` one clock later, with `out_valid` high. `out_soc` is high for the octet that carried `in_soc`. Cycles without a strobe give `out_valid` low.
- R3: When bit4 is 1, octet five of every valid cell (`in_idle`=0) must equal 0x55. Any other value raises the error flag.
- R4: When bit4 is 0, octet five of successive valid cells must alternate 0x55, 0xAA, 0x55, and so on, starting with 0x55 after reset. The expected value flips after every valid cell whether it matched or not, and in either mode. Idle cells are neither checked nor counted.
- R5: The error flag (bit0) stays set until a read of the register (`reg_rd`), which clears it. An error in the same cycle wins over the read. Writes leave bit0 unchanged and load bits 7..1 from `reg_wdata`.
- R6: `irq` is high exactly while bit0 and bit2 are both 1.
- R7: When the check sequence is enabled for a cell, output octet five is the CRC-8 (generator x^8+x^2+x+1, initial value 0) of output octets one to four, MSB first. When bit6 is 1 this value is XORed with 0x55.
- R8: Check-sequence insertion is governed by bit5 for valid cells and by bit1 for idle cells. When the relevant bit is 0, octet five passes through unchanged.
- R9: When bit3 is 1, bits 7..4 of the first octet are replaced by the last four `gfc_serial` samples taken on the clocks before it, the earliest sample in bit 7. Bits 3..0 pass through.
- R10: When bit7 is 1, output octets 6 to 53 are scrambled by y(t)=x(t) XOR y(t-43), bit by bit, MSB first. The scrambler history starts at zero and carries across cells. When bit7 is 0, the payload passes unchanged and the history is held. Octets 1 to 5 are never scrambled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input octet strobe |
| in_soc | input | 1 | Input octet is the first of a cell |
| in_idle | input | 1 | Cell tag, sampled with `in_soc`: 1 = idle cell |
| in_data | input | 8 | Input octet |
| gfc_serial | input | 1 | Serial source for the header nibble, sampled every clock |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe (clears bit0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register contents |
| out_valid | output | 1 | Output octet strobe |
| out_soc | output | 1 | Output octet is the first of a cell |
| out_data | output | 8 | Processed octet |
| irq | output | 1 | Integrity-error interrupt |

## Verification
Every processed octet is due on the clock edge that follows its strobe. The bench drives each octet on a falling edge and compares the output 1 ns after the next rising edge. The error flag is raised by the same edge that captures octet five. The bench therefore checks `irq` and reads the register only after the whole cell has been sent. `reg_rdata` is combinational, so a read is sampled during its strobe, before the edge that clears the flag. The nibble bits are driven on the four clocks just before the start octet, so the four-deep shift chain holds exactly those bits when the first octet is captured.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam int SCR_LEN = 43;

  typedef struct packed {
    logic scr_en;
    logic coset_en;
    logic hec_valid_en;
    logic pat_const;
    logic gfc_en;
    logic irq_en;
    logic hec_idle_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 7'b1111001;

  // CRC-8, generator x^8+x^2+x+1, one octet MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    logic fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  // self-synchronous x^43+1 scrambler: returns {new history, scrambled octet}
  function automatic logic [SCR_LEN+7:0] scr_byte(input logic [SCR_LEN-1:0] hist, input logic [7:0] d);
    logic [SCR_LEN-1:0] h;
    logic [7:0] y;
    h = hist;
    for (int i = 7; i >= 0; i--) begin
      y[i] = d[i] ^ h[SCR_LEN-1];
      h    = {h[SCR_LEN-2:0], y[i]};
    end
    return {h, y};
  endfunction
endpackage

// File: rtl/atm_tx_ctrl_regs.sv
module atm_tx_ctrl_regs
  import atm_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  input  logic       err_evt,
  output ctrl_t      ctrl,
  output logic       status,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  ctrl_t ctrl_q;
  logic  status_q;
  logic  unused_wbit;

  assign unused_wbit = reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      status_q <= 1'b0;
    end else begin
      if (reg_wr) ctrl_q <= ctrl_t'(reg_wdata[7:1]);
      if (err_evt)     status_q <= 1'b1;
      else if (reg_rd) status_q <= 1'b0;
    end
  end

  assign ctrl      = ctrl_q;
  assign status    = status_q;
  assign reg_rdata = {ctrl_q, status_q};
  assign irq       = status_q & ctrl_q.irq_en;
endmodule

// File: rtl/atm_tx_cell_track.sv
module atm_tx_cell_track #(
  parameter int CELL_LEN = 53,
  parameter int POS_W    = $clog2(CELL_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_soc,
  input  logic             in_idle,
  output logic [POS_W-1:0] pos,
  output logic             cur_idle
);
  localparam logic [POS_W-1:0] LAST = POS_W'(CELL_LEN - 1);

  logic [POS_W-1:0] cnt_q;
  logic             idle_q;

  assign pos      = in_soc ? '0 : cnt_q;
  assign cur_idle = in_soc ? in_idle : idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else if (in_valid) begin
      cnt_q  <= (pos == LAST) ? '0 : pos + 1'b1;
      idle_q <= cur_idle;
    end
  end
endmodule

// File: rtl/atm_tx_integrity.sv
module atm_tx_integrity #(
  parameter int POS_W   = 6,
  parameter int CHK_POS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [POS_W-1:0] pos,
  input  logic             cur_idle,
  input  logic [7:0]       in_data,
  input  logic             pat_const,
  output logic             err_evt
);
  logic       alt_q;
  logic       chk_now;
  logic [7:0] expect_b;

  assign chk_now  = in_valid && !cur_idle && (pos == POS_W'(CHK_POS));
  assign expect_b = (pat_const || !alt_q) ? 8'h55 : 8'hAA;
  assign err_evt  = chk_now && (in_data != expect_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       alt_q <= 1'b0;
    else if (chk_now) alt_q <= ~alt_q;
  end
endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc
  import atm_tx_pkg::*;
#(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_soc,
  input  logic       in_idle,
  input  logic [7:0] in_data,
  input  logic       gfc_serial,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       out_valid,
  output logic       out_soc,
  output logic [7:0] out_data,
  output logic       irq
);
  localparam int POS_W   = $clog2(CELL_LEN);
  localparam int CHK_POS = HDR_LEN - 1;
  localparam logic [POS_W-1:0] HEC_AT = POS_W'(CHK_POS);
  localparam logic [POS_W-1:0] PAY_AT = POS_W'(HDR_LEN);

  ctrl_t            ctrl;
  logic             status;
  logic             err_evt;
  logic [POS_W-1:0] pos;
  logic             cur_idle;

  logic [3:0]         gfc_sr;
  logic [7:0]         crc_q;
  logic [SCR_LEN-1:0] scr_q;
  logic [SCR_LEN+7:0] scr_res;
  logic [7:0]         hdr_byte, hec_val, mod_byte;
  logic               hec_on, scr_fire;
  logic               out_valid_q, out_soc_q;
  logic [7:0]         out_data_q;

  atm_tx_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .err_evt(err_evt), .ctrl(ctrl),
    .status(status), .reg_rdata(reg_rdata), .irq(irq)
  );

  atm_tx_cell_track #(.CELL_LEN(CELL_LEN), .POS_W(POS_W)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
    .in_idle(in_idle), .pos(pos), .cur_idle(cur_idle)
  );

  atm_tx_integrity #(.POS_W(POS_W), .CHK_POS(CHK_POS)) u_chk_byte (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pos(pos),
    .cur_idle(cur_idle), .in_data(in_data), .pat_const(ctrl.pat_const),
    .err_evt(err_evt)
  );

  assign hdr_byte = (pos == '0 && ctrl.gfc_en) ? {gfc_sr, in_data[3:0]} : in_data;
  assign hec_val  = crc_q ^ (ctrl.coset_en ? 8'h55 : 8'h00);
  assign hec_on   = cur_idle ? ctrl.hec_idle_en : ctrl.hec_valid_en;
  assign scr_res  = scr_byte(scr_q, in_data);
  assign scr_fire = in_valid && ctrl.scr_en && (pos >= PAY_AT);

  always_comb begin
    mod_byte = hdr_byte;
    if (pos == HEC_AT && hec_on)           mod_byte = hec_val;
    else if (pos >= PAY_AT && ctrl.scr_en) mod_byte = scr_res[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gfc_sr      <= '0;
      crc_q       <= '0;
      scr_q       <= '0;
      out_valid_q <= 1'b0;
      out_soc_q   <= 1'b0;
      out_data_q  <= '0;
    end else begin
      gfc_sr      <= {gfc_sr[2:0], gfc_serial};
      out_valid_q <= in_valid;
      out_soc_q   <= in_valid && in_soc;
      if (in_valid) begin
        out_data_q <= mod_byte;
        if (pos < HEC_AT) crc_q <= crc8_step((pos == '0) ? 8'h00 : crc_q, hdr_byte);
      end
      if (scr_fire) scr_q <= scr_res[SCR_LEN+7:8];
    end
  end

  assign out_valid = out_valid_q;
  assign out_soc   = out_soc_q;
  assign out_data  = out_data_q;
endmodule

// File: rtl/atm_tx_cell_proc_chk.sv
module atm_tx_cell_proc_chk #(
  parameter int POS_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_soc,
  input logic [7:0]       in_data,
  input logic [POS_W-1:0] pos,
  input logic             out_valid,
  input logic             out_soc,
  input logic [7:0]       out_data,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [7:0]       reg_rdata,
  input logic             status,
  input logic             err_evt,
  input logic             irq
);
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_gap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_soc_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_soc) |=> out_soc);
  a_r10_header_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos >= 1 && pos <= 3) |=> (out_data == $past(in_data)));
  a_r5_error_sets: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> status);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !reg_rd) |=> status);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !err_evt) |=> !status);
  a_r5_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !status && !err_evt) |=> !status);
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_rdata[0] && reg_rdata[2]));
endmodule

bind atm_tx_cell_proc atm_tx_cell_proc_chk #(.POS_W(POS_W)) u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
  .in_data(in_data), .pos(pos), .out_valid(out_valid), .out_soc(out_soc),
  .out_data(out_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .status(status), .err_evt(err_evt), .irq(irq)
);

// File: tb/tb_atm_tx_cell_proc.sv
module tb_atm_tx_cell_proc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_soc = 1'b0, in_idle = 1'b0, gfc_serial = 1'b0;
  logic [7:0] in_data = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, out_data;
  logic out_valid, out_soc, irq;

  int checks = 0, failures = 0;
  logic hist [0:42];
  int hp = 0;

  always #2 clk = ~clk;

  atm_tx_cell_proc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
    .in_idle(in_idle), .in_data(in_data), .gfc_serial(gfc_serial),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .out_valid(out_valid), .out_soc(out_soc),
    .out_data(out_data), .irq(irq)
  );

  // {ctrl, idle, octet5, nibble, expected error}
  localparam logic [21:0] VEC [0:11] = '{
    {8'hF2, 1'b0, 8'h55, 4'h0, 1'b0},
    {8'hF2, 1'b0, 8'hAA, 4'h0, 1'b1},
    {8'hE2, 1'b0, 8'h55, 4'h0, 1'b0},
    {8'hE2, 1'b0, 8'hAA, 4'h0, 1'b0},
    {8'hE6, 1'b0, 8'hAA, 4'h0, 1'b1},
    {8'hE2, 1'b1, 8'h13, 4'h0, 1'b0},
    {8'hEA, 1'b0, 8'hAA, 4'hA, 1'b0},
    {8'h38, 1'b0, 8'h55, 4'h5, 1'b0},
    {8'h38, 1'b1, 8'h77, 4'h5, 1'b0},
    {8'h12, 1'b0, 8'h55, 4'h0, 1'b0},
    {8'h12, 1'b1, 8'h00, 4'h0, 1'b0},
    {8'hD6, 1'b0, 8'h55, 4'h0, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [31:0] hdr);
    logic [39:0] r;
    r = {hdr, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r[i-:9] = r[i-:9] ^ 9'h107;
    return r[7:0];
  endfunction

  task automatic ref_scr(input logic [7:0] x, output logic [7:0] y);
    for (int i = 7; i >= 0; i--) begin
      y[i] = x[i] ^ hist[hp];
      hist[hp] = y[i];
      hp = (hp + 1) % 43;
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic read_reg(output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic send_cell(input logic [7:0] ctrl, input logic idle, input logic [7:0] b5,
                           input logic [3:0] nib, input int seed, input bit gaps);
    logic [7:0] h [0:3];
    logic [7:0] d, e, hec;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); in_valid = 1'b0; gfc_serial = nib[3-b];
    end
    for (int k = 0; k < 4; k++) h[k] = 8'(seed * 29 + k * 53 + 7);
    if (ctrl[3]) h[0] = {nib, h[0][3:0]};
    hec = ref_crc({h[0], h[1], h[2], h[3]}) ^ (ctrl[6] ? 8'h55 : 8'h00);
    for (int k = 0; k < 53; k++) begin
      if (k < 4) d = 8'(seed * 29 + k * 53 + 7);
      else if (k == 4) d = b5;
      else d = 8'(seed * 11 + k * 7 + 1);
      if (k < 4) e = h[k];
      else if (k == 4) e = ((idle ? ctrl[1] : ctrl[5]) ? hec : b5);
      else if (ctrl[7]) ref_scr(d, e);
      else e = d;
      @(negedge clk);
      in_valid = 1'b1; in_soc = (k == 0); in_idle = idle; in_data = d;
      @(posedge clk); #1;
      if (k == 0)      check("R9 first octet", out_data, e);
      else if (k == 4) check("R7/R8 octet five", out_data, e);
      else if (k > 4)  check("R10 payload", out_data, e);
      else             check("R2 header", out_data, e);
      check("R2 strobe/soc", {6'b0, out_valid, out_soc}, {6'b0, 1'b1, k == 0});
      if (gaps && (k % 9 == 3)) begin
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1 check("R2 gap", {7'b0, out_valid}, 8'h00);
      end
    end
    @(negedge clk); in_valid = 1'b0; in_soc = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rv, c;
    for (int i = 0; i < 43; i++) hist[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    check("R1 register", reg_rdata, 8'hF2);
    check("R1 irq/out_valid", {6'b0, irq, out_valid}, 8'h00);

    // table of cells
    for (int n = 0; n < 12; n++) begin
      c = VEC[n][21:14];
      write_reg(c | 8'h01);
      send_cell(c, VEC[n][13], VEC[n][12:5], VEC[n][4:1], n, 1'b0);
      check("R6 irq", {7'b0, irq}, {7'b0, VEC[n][0] & c[2]});
      read_reg(rv);
      check("R3/R4/R5 flag", {7'b0, rv[0]}, {7'b0, VEC[n][0]});
      check("R5 write leaves flag", rv & 8'hFE, c);
    end

    // R5: flag survives a write, clears on read
    write_reg(8'hF2);
    send_cell(8'hF2, 1'b0, 8'hAA, 4'h0, 20, 1'b0);
    write_reg(8'hF2);
    read_reg(rv);
    check("R5 flag after write", rv, 8'hF3);
    read_reg(rv);
    check("R5 flag after read", rv, 8'hF2);

    // R6: enable gating while flag held
    write_reg(8'hF6);
    check("R6 irq no flag", {7'b0, irq}, 8'h00);
    send_cell(8'hF6, 1'b0, 8'h00, 4'h0, 21, 1'b1);
    check("R6 irq raised", {7'b0, irq}, 8'h01);
    write_reg(8'hF2);
    check("R6 irq masked", {7'b0, irq}, 8'h00);
    read_reg(rv);
    check("R5 flag held under mask", {7'b0, rv[0]}, 8'h01);

    // R3: good cell with gaps leaves flag clear
    send_cell(8'hF2, 1'b0, 8'h55, 4'h0, 22, 1'b1);
    read_reg(rv);
    check("R3 good cell", {7'b0, rv[0]}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule